// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a device among four global power states: full run, reduced run, sleep and deep hibernation. For each controllable resource it drives a clock-gate enable and a bias enable. In the two run states those enables come from a per-state resource template that firmware programs. In the low-power states every resource is switched off.

Firmware writes the two templates and requests state changes through a small write port. Categorised wake inputs bring the device back from sleep or hibernation. Each return passes through a countdown whose length depends on the state being left, which stands in for regulator settling. After the countdown the block lands in full run with the processor resource turned back on.

Reset-class sources bypass the countdown and return to full run at once. The present state and the categories behind the most recent wake are readable at all times. The wake record clears when firmware acknowledges it.

Top module: `pm_seq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `cur_mode` is 0 (full run), `wake_cause` is 0 and both templates hold all ones, so every `clk_en` and `bias_en` bit is high.
- R2: `cur_mode` encodes 0 = full run, 1 = reduced run, 2 = sleep, 3 = hibernate, 4 = waking. In state 0 each `clk_en[i]` and `bias_en[i]` equals bit i of the full-run template. In state 1 they equal bit i of the reduced-run template.
- R3: A write with `cfg_addr` 0 loads the full-run template and `cfg_addr` 1 loads the reduced-run template, at any time. `cfg_addr` 2 is a state request whose code is `cfg_wdata[1:0]`, using the R2 encoding. The request takes effect at the next clock edge only in states 0 or 1; in any other state it is ignored.
- R4: In states 2, 3 and 4 every `clk_en` and `bias_en` bit is low.
- R5: In sleep, a peripheral, supervisor, tick or pin wake moves the block to state 4. It stays there for exactly `SLEEP_DLY` cycles and then enters state 0.
- R6: In hibernate only a pin wake is accepted. It gives `HIB_DLY` cycles in state 4 and then state 0. Peripheral, supervisor and tick wakes leave the state and `wake_cause` untouched.
- R7: Any of `rst_ext`, `rst_wdog` or `rst_prec` puts the block in state 0 at the next edge from every state, with no countdown.
- R8: Bit 0 of the full-run template is the processor enable. It is set to 1 whenever the block enters state 0 through a wake or reset source. In states 0 and 1 any accepted wake also moves the block to state 0 at the next edge.
- R9: `wake_cause` records the categories accepted in the last wake cycle: bit 0 peripheral, bit 1 supervisor, bit 2 tick, bit 3 pin, bit 4 reset source. A `cause_rd` pulse clears it, unless a wake is accepted in the same cycle, in which case the new record wins.
- R10: In state 4, non-reset wakes are ignored. They change neither the countdown nor `wake_cause`.
- R11: Template contents are kept through sleep, hibernate and waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 full-run template, 1 reduced-run template, 2 state request |
| cfg_wdata | input | NRES | Write data |
| cause_rd | input | 1 | Acknowledge pulse that clears the wake record |
| wk_periph | input | 1 | Enabled internal peripheral interrupt |
| wk_supv | input | 1 | Power supervisor event |
| wk_tick | input | 1 | Periodic timer tick |
| wk_pin | input | 1 | External pin interrupt |
| rst_ext | input | 1 | External reset pin event |
| rst_wdog | input | 1 | Watchdog reset event |
| rst_prec | input | 1 | Precision reset event |
| cur_mode | output | 3 | Present state (R2 encoding) |
| wake_cause | output | 5 | Wake category record |
| clk_en | output | NRES | Per-resource clock-gate enable |
| bias_en | output | NRES | Per-resource bias enable |

## Verification
The assertions assume that every wake and reset input is already synchronous to `clk` and is sampled as a level at each edge. They also assume that both delay parameters are at least 1. The stimulus changes inputs only on the falling edge. It raises each wake or reset line for exactly one cycle. It also covers cases the properties have to tolerate: simultaneous wake categories, acknowledges that coincide with new wakes, and state requests made while asleep.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE = 3'd0,
        PM_ALT    = 3'd1,
        PM_SLEEP  = 3'd2,
        PM_HIBER  = 3'd3,
        PM_WAKING = 3'd4
    } pm_mode_e;

    // bit order matches the wake_cause port: rst=4 pin=3 tick=2 supv=1 periph=0
    typedef struct packed {
        logic rst;
        logic pin;
        logic tick;
        logic supv;
        logic periph;
    } wake_src_t;

    localparam int CAUSE_W = 5;

    localparam logic [1:0] ADDR_ACT = 2'd0;
    localparam logic [1:0] ADDR_ALT = 2'd1;
    localparam logic [1:0] ADDR_REQ = 2'd2;

    function automatic pm_mode_e req_to_mode(input logic [1:0] code);
        case (code)
            2'd0:    return PM_ACTIVE;
            2'd1:    return PM_ALT;
            2'd2:    return PM_SLEEP;
            default: return PM_HIBER;
        endcase
    endfunction

    function automatic logic is_run(input pm_mode_e m);
        return (m == PM_ACTIVE) || (m == PM_ALT);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pm_wake_qual.sv
`timescale 1ns/1ps
// Filters raw wake inputs by the present state.
module pm_wake_qual
    import pm_pkg::*;
(
    input  pm_mode_e  mode,
    input  wake_src_t src,
    output wake_src_t acc,
    output logic      wake_any,
    output logic      rst_hit
);
    always_comb begin
        acc     = '0;
        acc.rst = src.rst;
        if (mode != PM_WAKING) begin
            acc.pin = src.pin;
        end
        if (is_run(mode) || mode == PM_SLEEP) begin
            acc.tick   = src.tick;
            acc.supv   = src.supv;
            acc.periph = src.periph;
        end
        wake_any = acc.pin | acc.tick | acc.supv | acc.periph;
        rst_hit  = acc.rst;
    end
endmodule

// File: rtl/pm_mode_fsm.sv
`timescale 1ns/1ps
// Global state register plus resume countdown.
module pm_mode_fsm
    import pm_pkg::*;
#(
    parameter int SLEEP_DLY = 1875,
    parameter int HIB_DLY   = 12500
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wake_any,
    input  logic     rst_hit,
    input  logic     req_valid,
    input  logic [1:0] req_code,
    output pm_mode_e mode,
    output logic     cpu_force
);
    localparam int CW = $clog2(imax(SLEEP_DLY, HIB_DLY) + 1);
    localparam logic [CW-1:0] SLP_LOAD = CW'(SLEEP_DLY - 1);
    localparam logic [CW-1:0] HIB_LOAD = CW'(HIB_DLY - 1);

    pm_mode_e      mode_q, mode_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        mode_d    = mode_q;
        cnt_d     = cnt_q;
        cpu_force = 1'b0;
        if (rst_hit) begin
            mode_d    = PM_ACTIVE;
            cnt_d     = '0;
            cpu_force = 1'b1;
        end else begin
            case (mode_q)
                PM_ACTIVE, PM_ALT: begin
                    if (wake_any) begin
                        mode_d    = PM_ACTIVE;
                        cpu_force = 1'b1;
                    end else if (req_valid) begin
                        mode_d = req_to_mode(req_code);
                    end
                end
                PM_SLEEP: if (wake_any) begin
                    mode_d = PM_WAKING;
                    cnt_d  = SLP_LOAD;
                end
                PM_HIBER: if (wake_any) begin
                    mode_d = PM_WAKING;
                    cnt_d  = HIB_LOAD;
                end
                PM_WAKING: begin
                    if (cnt_q == '0) begin
                        mode_d    = PM_ACTIVE;
                        cpu_force = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: mode_d = PM_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_ACTIVE;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/pm_tmpl_regs.sv
`timescale 1ns/1ps
// The two resource templates; processor bit forced on at wake.
module pm_tmpl_regs
    import pm_pkg::*;
#(
    parameter int NRES    = 8,
    parameter int CPU_IDX = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [NRES-1:0] wdata,
    input  logic            cpu_force,
    output logic [NRES-1:0] act_tmpl,
    output logic [NRES-1:0] alt_tmpl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act_tmpl <= '1;
            alt_tmpl <= '1;
        end else begin
            if (we && addr == ADDR_ACT) act_tmpl <= wdata;
            if (we && addr == ADDR_ALT) alt_tmpl <= wdata;
            if (cpu_force) act_tmpl[CPU_IDX] <= 1'b1;
        end
    end
endmodule

// File: rtl/pm_seq_ctrl.sv
`timescale 1ns/1ps
module pm_seq_ctrl
    import pm_pkg::*;
#(
    parameter int NRES      = 8,
    parameter int SLEEP_DLY = 1875,
    parameter int HIB_DLY   = 12500
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [NRES-1:0]     cfg_wdata,
    input  logic                cause_rd,
    input  logic                wk_periph,
    input  logic                wk_supv,
    input  logic                wk_tick,
    input  logic                wk_pin,
    input  logic                rst_ext,
    input  logic                rst_wdog,
    input  logic                rst_prec,
    output logic [2:0]          cur_mode,
    output logic [CAUSE_W-1:0]  wake_cause,
    output logic [NRES-1:0]     clk_en,
    output logic [NRES-1:0]     bias_en
);
    wake_src_t       src, acc;
    logic            wake_any, rst_hit, cpu_force;
    pm_mode_e        mode;
    logic [NRES-1:0] act_tmpl, alt_tmpl;
    logic [CAUSE_W-1:0] cause_q;

    always_comb begin
        src.rst    = rst_ext | rst_wdog | rst_prec;
        src.pin    = wk_pin;
        src.tick   = wk_tick;
        src.supv   = wk_supv;
        src.periph = wk_periph;
    end

    pm_wake_qual u_qual (
        .mode     (mode),
        .src      (src),
        .acc      (acc),
        .wake_any (wake_any),
        .rst_hit  (rst_hit)
    );

    pm_mode_fsm #(.SLEEP_DLY(SLEEP_DLY), .HIB_DLY(HIB_DLY)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wake_any  (wake_any),
        .rst_hit   (rst_hit),
        .req_valid (cfg_we && cfg_addr == ADDR_REQ),
        .req_code  (cfg_wdata[1:0]),
        .mode      (mode),
        .cpu_force (cpu_force)
    );

    pm_tmpl_regs #(.NRES(NRES), .CPU_IDX(0)) u_tmpl (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .cpu_force (cpu_force),
        .act_tmpl  (act_tmpl),
        .alt_tmpl  (alt_tmpl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else if (wake_any || rst_hit) begin
            cause_q <= acc;
        end else if (cause_rd) begin
            cause_q <= '0;
        end
    end

    for (genvar i = 0; i < NRES; i++) begin : g_res
        logic on;
        assign on         = (mode == PM_ACTIVE && act_tmpl[i]) ||
                            (mode == PM_ALT    && alt_tmpl[i]);
        assign clk_en[i]  = on;
        assign bias_en[i] = on;
    end

    assign cur_mode   = mode;
    assign wake_cause = cause_q;
endmodule

// File: rtl/pm_seq_ctrl_chk.sv
`timescale 1ns/1ps
module pm_seq_ctrl_chk #(
    parameter int NRES = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            wk_periph,
    input logic            wk_supv,
    input logic            wk_tick,
    input logic            wk_pin,
    input logic            rst_ext,
    input logic            rst_wdog,
    input logic            rst_prec,
    input logic [2:0]      cur_mode,
    input logic [4:0]      wake_cause,
    input logic [NRES-1:0] clk_en,
    input logic [NRES-1:0] bias_en
);
    logic any_rst, any_wk;
    assign any_rst = rst_ext | rst_wdog | rst_prec;
    assign any_wk  = wk_periph | wk_supv | wk_tick | wk_pin;

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cur_mode <= 3'd4); // R2

    AST_LOWPWR_GATED: assert property (@(posedge clk) disable iff (rst)
        (cur_mode >= 3'd2) |-> (clk_en == '0 && bias_en == '0)); // R4

    AST_RESET_TO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        any_rst |=> cur_mode == 3'd0); // R7

    AST_CPU_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        any_rst |=> clk_en[0]); // R8

    AST_CAUSE_RESET: assert property (@(posedge clk) disable iff (rst)
        any_rst |=> wake_cause[4]); // R9

    AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd2 && any_wk && !any_rst) |=> cur_mode == 3'd4); // R5

    AST_HIB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd3 && !wk_pin && !any_rst) |=> cur_mode == 3'd3); // R6

    AST_WAKING_EXIT: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd4) |=> (cur_mode == 3'd4 || cur_mode == 3'd0)); // R5
endmodule

bind pm_seq_ctrl pm_seq_ctrl_chk #(.NRES(NRES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wk_periph  (wk_periph),
    .wk_supv    (wk_supv),
    .wk_tick    (wk_tick),
    .wk_pin     (wk_pin),
    .rst_ext    (rst_ext),
    .rst_wdog   (rst_wdog),
    .rst_prec   (rst_prec),
    .cur_mode   (cur_mode),
    .wake_cause (wake_cause),
    .clk_en     (clk_en),
    .bias_en    (bias_en)
);

// File: tb/pm_seq_ctrl_test.sv
`timescale 1ns/1ps
module pm_seq_ctrl_test;
    localparam int N   = 8;
    localparam int SLP = 6;
    localparam int HIB = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic we = 0, rd = 0;
    logic [1:0] addr = 0;
    logic [N-1:0] wdata = 0;
    logic periph = 0, supv = 0, tick = 0, pin = 0, xr = 0, wd = 0, pr = 0;
    logic [2:0] cur_mode;
    logic [4:0] wake_cause;
    logic [N-1:0] clk_en, bias_en;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    int m_mode = 0, m_cnt = 0;
    logic [N-1:0] m_act = '1, m_alt = '1;
    logic [4:0] m_cause = 0;

    always #4 clk = ~clk;

    pm_seq_ctrl #(.NRES(N), .SLEEP_DLY(SLP), .HIB_DLY(HIB)) uut (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
        .cause_rd(rd), .wk_periph(periph), .wk_supv(supv), .wk_tick(tick),
        .wk_pin(pin), .rst_ext(xr), .rst_wdog(wd), .rst_prec(pr),
        .cur_mode(cur_mode), .wake_cause(wake_cause), .clk_en(clk_en), .bias_en(bias_en)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic rs;
        int acc, nm;
        bit force_cpu;
        rs = xr | wd | pr;
        acc = 0;
        if (rs) acc |= 16;
        if (pin && m_mode != 4) acc |= 8;
        if (m_mode <= 2) begin
            if (tick)   acc |= 4;
            if (supv)   acc |= 2;
            if (periph) acc |= 1;
        end
        force_cpu = 0;
        nm = m_mode;
        if (rs) begin
            nm = 0; force_cpu = 1;
        end else if (m_mode <= 1) begin
            if (acc != 0) begin nm = 0; force_cpu = 1; end
            else if (we && addr == 2) nm = int'(wdata[1:0]);
        end else if (m_mode == 2 || m_mode == 3) begin
            if (acc != 0) begin nm = 4; m_cnt = (m_mode == 2) ? SLP : HIB; end
        end else begin
            m_cnt--;
            if (m_cnt == 0) begin nm = 0; force_cpu = 1; end
        end
        if (we && addr == 0) m_act = wdata;
        if (we && addr == 1) m_alt = wdata;
        if (force_cpu) m_act[0] = 1'b1;
        if (acc != 0) m_cause = 5'(acc);
        else if (rd) m_cause = 0;
        m_mode = nm;
    endtask

    task automatic cyc(input string tag);
        logic [N-1:0] exp_en;
        model_step();
        @(posedge clk);
        @(negedge clk);
        exp_en = (m_mode == 0) ? m_act : (m_mode == 1) ? m_alt : '0;
        chk(tag, "cur_mode", int'(cur_mode), m_mode);
        chk(tag, "clk_en", int'(clk_en), int'(exp_en));
        chk(tag, "bias_en", int'(bias_en), int'(exp_en));
        chk(tag, "wake_cause", int'(wake_cause), int'(m_cause));
        we = 0; rd = 0; periph = 0; supv = 0; tick = 0; pin = 0; xr = 0; wd = 0; pr = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d, input string tag);
        we = 1; addr = a; wdata = d;
        cyc(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "mode after reset", int'(cur_mode), 0);
        chk("R1", "cause after reset", int'(wake_cause), 0);
        chk("R1", "enables after reset", int'(clk_en), 8'hFF);
        idle(2, "R1");

        // R2 / R3 templates and run-state requests
        wr(2'd0, 8'hA5, "R3");
        wr(2'd1, 8'h3C, "R3");
        wr(2'd2, 8'd1, "R2");
        idle(2, "R2");
        wr(2'd1, 8'h0F, "R3");
        wr(2'd2, 8'd0, "R2");
        idle(1, "R2");

        // R8 processor bit cleared then restored by a wake in full run
        wr(2'd0, 8'hA4, "R8");
        chk("R8", "cpu bit cleared", int'(clk_en[0]), 0);
        tick = 1; cyc("R8");
        chk("R8", "cpu restored", int'(clk_en[0]), 1);
        rd = 1; cyc("R9");
        // wake in reduced run returns to full run
        wr(2'd2, 8'd1, "R8");
        wr(2'd0, 8'hA4, "R8");
        supv = 1; cyc("R8");

        // R5 sleep wakes, each category
        for (int k = 0; k < 4; k++) begin
            wr(2'd2, 8'd2, "R5");
            wr(2'd2, 8'd1, "R3");         // request ignored while asleep
            idle(2, "R4");
            case (k)
                0: periph = 1;
                1: supv = 1;
                2: tick = 1;
                default: pin = 1;
            endcase
            cyc("R5");
            idle(SLP + 1, "R5");
            rd = 1; cyc("R9");
        end

        // R6 hibernate ignores all but the pin
        wr(2'd0, 8'h5A, "R11");
        wr(2'd2, 8'd3, "R6");
        tick = 1; cyc("R6");
        supv = 1; periph = 1; cyc("R6");
        wr(2'd2, 8'd0, "R3");
        idle(3, "R6");
        pin = 1; tick = 1; cyc("R6");
        // R10 wakes during countdown ignored
        tick = 1; supv = 1; cyc("R10");
        pin = 1; cyc("R10");
        idle(HIB, "R6");
        chk("R11", "template kept", int'(clk_en), 8'h5B);

        // R9 acknowledge coinciding with a wake
        rd = 1; periph = 1; cyc("R9");
        rd = 1; cyc("R9");

        // R7 reset sources from each low-power state
        wr(2'd2, 8'd2, "R7");
        xr = 1; cyc("R7");
        wr(2'd2, 8'd3, "R7");
        idle(2, "R7");
        wd = 1; cyc("R7");
        wr(2'd2, 8'd2, "R7");
        tick = 1; cyc("R7");
        idle(2, "R7");
        pr = 1; pin = 1; cyc("R7");
        wr(2'd2, 8'd3, "R7");
        pin = 1; cyc("R7");
        idle(3, "R7");
        xr = 1; cyc("R7");
        idle(3, "R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule